// File: doc/BRIEF.md
# Variable Page Size Software TLB

This block translates 32-bit effective addresses for a small embedded core through a fully associative, software-loaded table. Every entry carries its own page size, chosen from eight powers of four between 1 KB and 16 MB, together with an 8-bit translation tag. An entry takes part in a lookup only when it is valid and its tag equals the process ID presented with the request. The table is shared by instruction and data requests. Each side has its own enable, and when the enable for the requesting side is off, the address passes through unchanged.

Software fills the table through a write port that addresses one entry per cycle. There is no hardware refill. A lookup that finds no entry returns a miss flag together with the offending address, and the handler loads a suitable entry before retrying. The protection and attribute bits of the low word are stored with the entry but are not acted on.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_pa` and `rsp_fault_ea` read zero, and a translated lookup misses until an entry has been written.
- R2: When the enable for the requesting side is low, the response is a hit with `rsp_pa` equal to the request address, whatever the table holds.
- R3: `req_side` = 0 selects the instruction enable `xlate_en_i`, and `req_side` = 1 selects the data enable `xlate_en_d`.
- R4: An entry whose high word has bit 6 (valid) clear never matches.
- R5: An entry matches only when its stored 8-bit tag equals `cur_pid`.
- R6: The size code in high-word bits [9:7] selects the page size 1 KB << (2*code). The entry matches when the effective address and the high word agree on every bit above the page offset.
- R7: On a hit, `rsp_pa` is built from two parts: the bits of the low word above the page offset, and the bits of the effective address within the page. Low-word bits inside the offset, such as the attribute bits, have no effect on the address.
- R8: When several entries match, the entry with the lowest index supplies the translation.
- R9: A translated lookup with no match gives `rsp_miss` = 1, `rsp_hit` = 0 and `rsp_fault_ea` equal to the request address. `rsp_fault_ea` keeps its value until the next miss.
- R10: The response to a request sampled at one clock edge appears after that same edge, with `rsp_valid` = 1.
- R11: An entry write is visible to lookups from the cycle after the write. A lookup in the same cycle as a write uses the old contents.
- R12: In a cycle with no request, `rsp_valid`, `rsp_hit` and `rsp_miss` are all low on the next edge. `rsp_hit` and `rsp_miss` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Index of the entry to write |
| wr_hi | input | 32 | High word: page number, size code [9:7], valid [6] |
| wr_lo | input | 32 | Low word: real page number plus attribute bits |
| wr_tid | input | 8 | Translation tag of the entry |
| req_valid | input | 1 | Lookup request |
| req_side | input | 1 | 0 = instruction, 1 = data |
| req_ea | input | 32 | Effective address |
| cur_pid | input | 8 | Current process ID |
| xlate_en_i | input | 1 | Instruction-side translation enable |
| xlate_en_d | input | 1 | Data-side translation enable |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation found or pass-through |
| rsp_pa | output | 32 | Physical address |
| rsp_miss | output | 1 | Translation miss fault |
| rsp_fault_ea | output | 32 | Address of the most recent miss |

## Verification
Every lookup result is due exactly one edge after its request. An entry write changes what the following cycle's lookup sees, but not the lookup issued alongside it. The bench drives each cycle's request and write together on the falling edge. It computes the expected response from its own table model before applying that cycle's write, and compares all response ports on the next falling edge. Because this happens in every cycle, idle cycles, same-cycle write and lookup collisions, and the page boundaries of all eight sizes are all checked at the cycle in which their result must show.

// File: rtl/vpage_tlb.sv
module vpage_tlb #(
  parameter int ENTRIES = 64,
  parameter int TIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_hi,
  input  logic [31:0]     wr_lo,
  input  logic [TIDW-1:0] wr_tid,
  input  logic            req_valid,
  input  logic            req_side,
  input  logic [31:0]     req_ea,
  input  logic [TIDW-1:0] cur_pid,
  input  logic            xlate_en_i,
  input  logic            xlate_en_d,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [31:0]     rsp_pa,
  output logic            rsp_miss,
  output logic [31:0]     rsp_fault_ea
);

  logic [31:0]     hi_q  [ENTRIES];
  logic [31:0]     lo_q  [ENTRIES];
  logic [TIDW-1:0] tid_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  function automatic logic [31:0] size_mask(input logic [2:0] code);
    return 32'hFFFF_FFFF << (5'd10 + {1'b0, code, 1'b0});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_hi[6];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      hi_q[wr_idx]  <= wr_hi;
      lo_q[wr_idx]  <= wr_lo;
      tid_q[wr_idx] <= wr_tid;
    end
  end

  wire xlate_on = req_side ? xlate_en_d : xlate_en_i;

  logic        found;
  logic [31:0] found_pa;
  logic [31:0] m_t;

  always_comb begin
    found    = 1'b0;
    found_pa = '0;
    m_t      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      m_t = size_mask(hi_q[i][9:7]);
      if (vld_q[i] && tid_q[i] == cur_pid && ((req_ea ^ hi_q[i]) & m_t) == 32'd0) begin
        found    = 1'b1;
        found_pa = (lo_q[i] & m_t) | (req_ea & ~m_t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_pa       <= '0;
      rsp_fault_ea <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && (!xlate_on || found);
      rsp_miss  <= req_valid && xlate_on && !found;
      if (req_valid) rsp_pa <= !xlate_on ? req_ea : (found ? found_pa : 32'd0);
      if (req_valid && xlate_on && !found) rsp_fault_ea <= req_ea;
    end
  end

  // R12
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && (rsp_hit || rsp_miss)));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_side ? xlate_en_d : xlate_en_i)) |=> (rsp_hit && rsp_pa == $past(req_ea)));

  // R9
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $rose(rsp_miss)) |-> rsp_fault_ea == $past(req_ea));

  // R7
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_miss || rsp_pa[9:0] == $past(req_ea[9:0])));

endmodule

// File: tb/vpage_tlb_bench.sv
`timescale 1ns/1ps
module vpage_tlb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_en = 0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic [7:0]  wr_tid = '0;
  logic        req_valid = 0, req_side = 0;
  logic [31:0] req_ea = '0;
  logic [7:0]  cur_pid = '0;
  logic        xlate_en_i = 0, xlate_en_d = 0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_pa, rsp_fault_ea;

  vpage_tlb u_vpage_tlb (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_hi [64];
  logic [31:0] m_lo [64];
  logic [7:0]  m_tid [64];
  bit          m_v [64];
  logic [31:0] m_fault = '0;
  logic [31:0] masks [8] = '{32'hFFFFFC00, 32'hFFFFF000, 32'hFFFFC000, 32'hFFFF0000,
                             32'hFFFC0000, 32'hFFF00000, 32'hFFC00000, 32'hFF000000};

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit rv, input bit side, input logic [31:0] ea,
                     input logic [7:0] pid, input bit ei, input bit ed,
                     input bit we = 0, input logic [5:0] widx = 0,
                     input logic [31:0] whi = 0, input logic [31:0] wlo = 0,
                     input logic [7:0] wtid = 0);
    bit e_h, e_m, on, hitf;
    logic [31:0] e_pa, mk;
    req_valid = rv; req_side = side; req_ea = ea; cur_pid = pid;
    xlate_en_i = ei; xlate_en_d = ed;
    wr_en = we; wr_idx = widx; wr_hi = whi; wr_lo = wlo; wr_tid = wtid;
    on = side ? ed : ei;
    hitf = 0; e_pa = 0;
    for (int i = 0; i < 64 && !hitf; i++) begin
      mk = masks[m_hi[i][9:7]];
      if (m_v[i] && m_tid[i] == pid && (ea & mk) == (m_hi[i] & mk)) begin
        hitf = 1;
        e_pa = (m_lo[i] & mk) | (ea & ~mk);
      end
    end
    if (!on) e_pa = ea;
    e_h = rv && (!on || hitf);
    e_m = rv && on && !hitf;
    if (e_m) m_fault = ea;
    if (we) begin
      m_hi[widx] = whi; m_lo[widx] = wlo; m_tid[widx] = wtid; m_v[widx] = whi[6];
    end
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == rv, tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, rv});
    check(rsp_hit == e_h, tag, "rsp_hit", {31'd0, rsp_hit}, {31'd0, e_h});
    check(rsp_miss == e_m, tag, "rsp_miss", {31'd0, rsp_miss}, {31'd0, e_m});
    if (e_h) check(rsp_pa == e_pa, tag, "rsp_pa", rsp_pa, e_pa);
    check(rsp_fault_ea == m_fault, tag, "rsp_fault_ea", rsp_fault_ea, m_fault);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] psz;
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_hi[i] = 0; m_lo[i] = 0; m_tid[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid == 0 && rsp_hit == 0 && rsp_miss == 0, "R1", "flags", {29'd0, rsp_valid, rsp_hit, rsp_miss}, 0);
    check(rsp_pa == 0, "R1", "rsp_pa", rsp_pa, 0);
    rst_n = 1;
    cyc("R1", 1, 1, 32'h1234_5678, 8'd0, 1, 1);
    cyc("R12", 0, 0, 32'h0, 8'd0, 1, 1);
    // R2 / R3 pass-through per side
    cyc("R2", 1, 0, 32'hCAFE_0123, 8'd3, 0, 1);
    cyc("R3", 1, 1, 32'hCAFE_0456, 8'd3, 0, 1);
    cyc("R3", 1, 1, 32'hBEEF_0001, 8'd3, 1, 0);
    cyc("R3", 1, 0, 32'hBEEF_0002, 8'd3, 1, 0);
    // load entry 5: 64 KB page, tag 7, attribute bits in the low word
    cyc("R11", 0, 0, 0, 0, 1, 1, 1, 6'd5, 32'h1000_0000 | (3 << 7) | (1 << 6), 32'h2345_0ABC, 8'd7);
    // R6 R7 hit with size code 3
    cyc("R7", 1, 1, 32'h1000_1234, 8'd7, 1, 1);
    cyc("R6", 1, 0, 32'h1001_0000, 8'd7, 1, 1);
    // R5 tag mismatch
    cyc("R5", 1, 1, 32'h1000_1234, 8'd8, 1, 1);
    // R2 passthrough even though an entry matches
    cyc("R2", 1, 1, 32'h1000_1234, 8'd7, 1, 0);
    // R11 write entry 2 (1 KB page inside entry 5's range) and look up same cycle
    cyc("R11", 1, 1, 32'h1000_0420, 8'd7, 1, 1, 1, 6'd2, 32'h1000_0400 | (0 << 7) | (1 << 6), 32'h7770_0400, 8'd7);
    // R8 lowest index now wins
    cyc("R8", 1, 1, 32'h1000_0420, 8'd7, 1, 1);
    cyc("R8", 1, 1, 32'h1000_0820, 8'd7, 1, 1);
    // R4 clear valid on entry 2
    cyc("R4", 0, 0, 0, 0, 1, 1, 1, 6'd2, 32'h1000_0400, 32'h7770_0400, 8'd7);
    cyc("R4", 1, 1, 32'h1000_0420, 8'd7, 1, 1);
    // R4 invalid entry alone never hits
    cyc("R4", 0, 0, 0, 0, 1, 1, 1, 6'd20, 32'h5000_0000 | (7 << 7), 32'h6000_0000, 8'd7);
    cyc("R4", 1, 0, 32'h5000_0010, 8'd7, 1, 1);
    cyc("R12", 0, 0, 32'h5000_0010, 8'd7, 1, 1);
    // R6 every size code: inside the page hits, just past it misses
    for (int s = 0; s < 8; s++) begin
      psz = 32'd1024 << (2 * s);
      cyc("R6", 0, 0, 0, 0, 1, 1, 1, 6'd10, 32'h4000_0000 | (s << 7) | (1 << 6), 32'h8100_0000 | 32'h3F, 8'd9);
      cyc("R6", 1, 1, 32'h4000_0000 + psz / 2 + 3, 8'd9, 1, 1);
      cyc("R9", 1, 1, 32'h4000_0000 + psz, 8'd9, 1, 1);
      cyc("R7", 1, 0, 32'h4000_0000 + psz - 1, 8'd9, 1, 1);
      cyc("R10", 1, 1, 32'h3FFF_FFFF, 8'd9, 1, 1);
    end
    // R12 idle, then R1 reset clears valid bits
    cyc("R12", 0, 1, 32'h4000_0003, 8'd9, 1, 1);
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    m_fault = 0;
    cyc("R1", 1, 1, 32'h1000_1234, 8'd7, 1, 1);
    cyc("R1", 1, 0, 32'h4000_0003, 8'd9, 1, 1);
    finish_run();
  end
endmodule